// File: doc/BRIEF.md
# Legacy-Compatible Bus Cycle Sequencer

This block generates the memory bus cycles for three operand-access kinds of an 8-bit accumulator processor with a 16-bit address space: a jump through a two-byte pointer in memory, an indexed access (base plus an 8-bit index), and a read-modify-write of one memory byte. Instruction decode, the arithmetic unit and the register file sit outside it. A start pulse hands it the operation kind, the operand address, the index and the address of the last instruction byte. From the next clock it drives one bus cycle per clock until the final access is done.

A mode input chooses between two access patterns. Legacy mode reproduces the bus artefacts of early processors: the pointer fetch wraps inside its page, a page-crossing indexed access reads an un-carried address first, and a read-modify-write writes twice. Corrected mode uses the later patterns: the pointer fetch carries into the next page, the extra indexed read goes to the last instruction byte, and a read-modify-write reads twice and writes once. A ready input stalls read cycles only. The block reports the effective address with a one-clock done pulse.

Top module: `bus_cycle_seq`

## Requirements
- R1: While the block is idle, a start pulse with `op_kind` 0 (pointer jump), 1 (indexed) or 2 (read-modify-write) is accepted, and the first bus cycle appears in the next clock. A start with `op_kind` 3 is not accepted and produces no bus cycle.
- R2: In legacy mode a pointer jump reads the pointer address and then the address with the same high byte and the low byte plus one, wrapping within the page (pointer 10FF reads 10FF then 1000).
- R3: In corrected mode a pointer jump reads the pointer and then pointer+1 with carry. When the pointer low byte is FF, one extra read of the pointer address is inserted between the two (10FF reads 10FF, 10FF, 1100).
- R4: In legacy mode an indexed access whose sum crosses a page first reads the base high byte joined with the sum's low byte, then reads the full sum.
- R5: In corrected mode a page-crossing indexed access first reads `last_pc`, then the full sum.
- R6: An indexed access that stays within the base page issues a single read of the sum in either mode.
- R7: In legacy mode a read-modify-write reads the address, writes the byte just read back to it, then writes `mod_data` to it.
- R8: In corrected mode a read-modify-write reads the address twice, then writes `mod_data` once.
- R9: With `ready` low, a read cycle repeats with the same address and the sequence does not advance. A write cycle completes whatever `ready` is.
- R10: `done` is high for exactly one clock, in the cycle that completes the final access. In that cycle `eff_addr` holds the jump target ({high byte read, low byte read}), the indexed sum, or the read-modify-write address.
- R11: After reset the block is idle, with `bus_valid` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation (used only when idle) |
| op_kind | input | 2 | 0 pointer jump, 1 indexed, 2 read-modify-write, 3 none |
| legacy_mode | input | 1 | 1 = legacy patterns, 0 = corrected patterns |
| oper_addr | input | 16 | Pointer, base or target address |
| index | input | 8 | Index added for indexed access |
| last_pc | input | 16 | Address of the last instruction byte |
| rdata | input | 8 | Read data from memory |
| mod_data | input | 8 | Modified value for read-modify-write |
| ready | input | 1 | Low stalls read cycles |
| bus_valid | output | 1 | A bus cycle is driven this clock |
| bus_addr | output | 16 | Address of the current cycle |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write data |
| done | output | 1 | Final access completes this clock |
| eff_addr | output | 16 | Effective address, valid with done |

## Verification
Pointer jumps run with a pointer low byte of FF and with an ordinary low byte in both modes. This separates the wrap, the carry and the inserted cycle from the plain two-read fetch. Indexed accesses run with sums that cross and sums that stay in the page, so the dummy-read address (un-carried or last instruction byte) and its absence are both seen. Read-modify-write runs in both modes show the read/write order and the written values, and stall masks that hit read and write cycles show that only reads are held.

// File: rtl/bcs_pkg.sv
// Package: shared operation encoding and step-counter width for the
// bus cycle sequencer. Assumes at most three bus cycles per operation.
package bcs_pkg;
    typedef enum logic [1:0] {
        OP_PTR_JUMP = 2'd0,
        OP_INDEXED  = 2'd1,
        OP_RMW      = 2'd2,
        OP_NONE     = 2'd3
    } op_e;

    localparam int STEP_W = 2;
endpackage

// File: rtl/bcs_stepper.sv
// Step counter: tracks whether an operation is in progress and which of
// its cycles is on the bus. Assumes the cycle map flags the final cycle.
// Read cycles advance only with ready; write cycles always advance.
module bcs_stepper
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              cyc_we,
    input  logic              cyc_last,
    input  logic              ready,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              adv,
    output logic              done
);
    // A cycle completes when it is a write or when memory is ready.
    always_comb begin
        adv  = busy && (cyc_we || ready);
        done = adv && cyc_last;
    end

    // Start, step through and finish an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
        end else if (!busy) begin
            if (launch) begin
                busy <= 1'b1;
                step <= '0;
            end
        end else if (adv) begin
            if (cyc_last) begin
                busy <= 1'b0;
                step <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/bcs_cycle_map.sv
// Cycle map: from the latched operation and the current step, decides the
// address, direction, write data and whether this is the final cycle.
// Also forms the effective address. Purely combinational; assumes the
// page size equals 2**DATA_W bytes.
module bcs_cycle_map
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic              legacy,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] idx,
    input  logic [ADDR_W-1:0] pc,
    input  logic [STEP_W-1:0] step,
    input  logic [DATA_W-1:0] cap,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] mod_data,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              last,
    output logic [ADDR_W-1:0] eff
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] ptr_wrap;
    logic [ADDR_W-1:0] ptr_carry;
    logic              crosses;
    logic              low_full;

    // Candidate addresses shared by the per-kind sequences.
    always_comb begin
        sum       = base + ADDR_W'(idx);
        crosses   = sum[ADDR_W-1:DATA_W] != base[ADDR_W-1:DATA_W];
        low_full  = &base[DATA_W-1:0];
        ptr_wrap  = {base[ADDR_W-1:DATA_W], base[DATA_W-1:0] + DATA_W'(1)};
        ptr_carry = base + ADDR_W'(1);
    end

    // Per-kind, per-step bus cycle description.
    always_comb begin
        addr  = base;
        we    = 1'b0;
        wdata = '0;
        last  = 1'b1;
        eff   = base;
        case (op)
            OP_PTR_JUMP: begin
                eff = {rdata[HI_W-1:0], cap};
                case (step)
                    2'd0: begin addr = base; last = 1'b0; end
                    2'd1: begin
                        if (legacy) begin
                            addr = ptr_wrap;
                        end else if (low_full) begin
                            addr = base;
                            last = 1'b0;
                        end else begin
                            addr = ptr_carry;
                        end
                    end
                    default: addr = ptr_carry;
                endcase
            end
            OP_INDEXED: begin
                eff = sum;
                if (step == 2'd0 && crosses) begin
                    addr = legacy ? {base[ADDR_W-1:DATA_W], sum[DATA_W-1:0]} : pc;
                    last = 1'b0;
                end else begin
                    addr = sum;
                end
            end
            OP_RMW: begin
                case (step)
                    2'd0: last = 1'b0;
                    2'd1: begin
                        last  = 1'b0;
                        we    = legacy;
                        wdata = legacy ? cap : '0;
                    end
                    default: begin
                        we    = 1'b1;
                        wdata = mod_data;
                    end
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Top: latches an operation on start, drives its bus cycles through the
// cycle map and step counter, and captures the first byte read.
// Assumes start is only meaningful while idle.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic              legacy_mode,
    input  logic [ADDR_W-1:0] oper_addr,
    input  logic [DATA_W-1:0] index,
    input  logic [ADDR_W-1:0] last_pc,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] mod_data,
    input  logic              ready,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              done,
    output logic [ADDR_W-1:0] eff_addr
);
    op_e               op_q;
    logic              legacy_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] idx_q;
    logic [ADDR_W-1:0] pc_q;
    logic [DATA_W-1:0] cap_q;
    logic              busy;
    logic [STEP_W-1:0] step;
    logic              adv;
    logic              launch;
    logic [ADDR_W-1:0] m_addr;
    logic              m_we;
    logic [DATA_W-1:0] m_wdata;
    logic              m_last;

    // Accept a start only when idle and with a defined kind.
    always_comb launch = start && !busy && (op_e'(op_kind) != OP_NONE);

    // Latch operation fields at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            legacy_q <= 1'b0;
            base_q   <= '0;
            idx_q    <= '0;
            pc_q     <= '0;
        end else if (launch) begin
            op_q     <= op_e'(op_kind);
            legacy_q <= legacy_mode;
            base_q   <= oper_addr;
            idx_q    <= index;
            pc_q     <= last_pc;
        end
    end

    // Keep the byte returned by the first completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else if (adv && !m_we && step == '0) cap_q <= rdata;
    end

    bcs_stepper u_step (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cyc_we(m_we),
        .cyc_last(m_last), .ready(ready), .busy(busy), .step(step),
        .adv(adv), .done(done)
    );

    bcs_cycle_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_map (
        .op(op_q), .legacy(legacy_q), .base(base_q), .idx(idx_q),
        .pc(pc_q), .step(step), .cap(cap_q), .rdata(rdata),
        .mod_data(mod_data), .addr(m_addr), .we(m_we), .wdata(m_wdata),
        .last(m_last), .eff(eff_addr)
    );

    // Bus outputs are quiet while idle.
    always_comb begin
        bus_valid = busy;
        bus_addr  = busy ? m_addr : '0;
        bus_we    = busy && m_we;
        bus_wdata = busy ? m_wdata : '0;
    end
endmodule

// File: rtl/bcs_checker.sv
// Checker: temporal properties of the bus cycle sequencer, bound to the top.
module bcs_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              ready,
    input logic              bus_valid,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              done,
    input logic              legacy_q
);
    // R1: bus activity begins only after an accepted start.
    assert_start_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(start));

    // R9: a stalled read repeats at the same address.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && !ready) |=> (bus_valid && !bus_we && $stable(bus_addr)));

    // R9: a read never completes without ready.
    assert_done_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bus_we) |-> ready);

    // R10: done is a single pulse ending the operation.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_valid);

    // R7: a non-final write is followed by the final write to the same address.
    assert_dbl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !done) |=> (bus_valid && bus_we && done && $stable(bus_addr)));

    // R8: in corrected mode every write is the final access.
    assert_one_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && !legacy_q) |-> done);
endmodule

bind bus_cycle_seq bcs_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
    .done(done), .legacy_q(legacy_q)
);

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd3;
    logic        legacy_mode = 1'b0;
    logic [15:0] oper_addr = '0;
    logic [7:0]  index = '0;
    logic [15:0] last_pc = '0;
    logic [7:0]  rdata = '0;
    logic [7:0]  mod_data = 8'hC3;
    logic        ready = 1'b1;
    logic        bus_valid, bus_we, done;
    logic [15:0] bus_addr, eff_addr;
    logic [7:0]  bus_wdata;

    int checks = 0;
    int fails  = 0;

    logic [15:0] q_addr[$];
    logic        q_we[$];
    logic [7:0]  q_wd[$];

    always #4 clk = ~clk;

    bus_cycle_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .legacy_mode(legacy_mode), .oper_addr(oper_addr), .index(index),
        .last_pc(last_pc), .rdata(rdata), .mod_data(mod_data), .ready(ready),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .done(done), .eff_addr(eff_addr)
    );

    // Memory contents seen by the bench.
    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic w, input logic [7:0] d);
        q_addr.push_back(a);
        q_we.push_back(w);
        q_wd.push_back(d);
    endtask

    // Build the expected trace, launch, and compare on every clock.
    task automatic run_op(input string tag, input logic [1:0] kind, input logic leg,
                          input logic [15:0] a, input logic [7:0] x,
                          input logic [15:0] pc, input logic [15:0] stall);
        logic [15:0] s, hi, eff;
        int cyc;
        s = a + {8'h00, x};
        eff = a;
        case (kind)
            2'd0: begin
                push(a, 1'b0, 8'h00);
                if (!leg && a[7:0] == 8'hFF) push(a, 1'b0, 8'h00);
                hi = leg ? {a[15:8], a[7:0] + 8'd1} : a + 16'd1;
                push(hi, 1'b0, 8'h00);
                eff = {mem(hi), mem(a)};
            end
            2'd1: begin
                if (s[15:8] != a[15:8]) push(leg ? {a[15:8], s[7:0]} : pc, 1'b0, 8'h00);
                push(s, 1'b0, 8'h00);
                eff = s;
            end
            default: begin
                push(a, 1'b0, 8'h00);
                if (leg) push(a, 1'b1, mem(a));
                else push(a, 1'b0, 8'h00);
                push(a, 1'b1, mod_data);
            end
        endcase
        @(negedge clk);
        start = 1'b1; op_kind = kind; legacy_mode = leg;
        oper_addr = a; index = x; last_pc = pc;
        @(negedge clk);
        start = 1'b0; op_kind = 2'd3;
        cyc = 0;
        while (q_addr.size() > 0 && cyc < 40) begin
            logic expd;
            ready = !stall[cyc % 16];
            #1;
            rdata = mem(bus_addr);
            #1;
            chk(tag, "valid", 32'(bus_valid), 32'd1);
            chk(tag, "addr", 32'(bus_addr), 32'(q_addr[0]));
            chk(tag, "we", 32'(bus_we), 32'(q_we[0]));
            if (q_we[0]) chk(tag, "wdata", 32'(bus_wdata), 32'(q_wd[0]));
            expd = (q_addr.size() == 1) && (q_we[0] || ready);
            chk({tag, " R10"}, "done", 32'(done), 32'(expd));
            if (expd) chk({tag, " R10"}, "eff_addr", 32'(eff_addr), 32'(eff));
            if (q_we[0] || ready) begin
                void'(q_addr.pop_front());
                void'(q_we.pop_front());
                void'(q_wd.pop_front());
            end
            cyc++;
            @(negedge clk);
        end
        ready = 1'b1;
        #1;
        chk({tag, " R10"}, "idle after done", 32'(bus_valid), 32'd0);
        q_addr.delete(); q_we.delete(); q_wd.delete();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "valid in reset", 32'(bus_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "valid after reset", 32'(bus_valid), 32'd0);
        chk("R11", "done after reset", 32'(done), 32'd0);

        // R1: undefined kind is not accepted
        start = 1'b1; op_kind = 2'd3;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R1", "valid after kind 3", 32'(bus_valid), 32'd0);

        run_op("R1 R2",  2'd0, 1'b1, 16'h10FF, 8'h00, 16'h0000, 16'h0000);
        run_op("R2",     2'd0, 1'b1, 16'h2034, 8'h00, 16'h0000, 16'h0000);
        run_op("R3",     2'd0, 1'b0, 16'h10FF, 8'h00, 16'h0000, 16'h0000);
        run_op("R3",     2'd0, 1'b0, 16'h2034, 8'h00, 16'h0000, 16'h0000);
        run_op("R4",     2'd1, 1'b1, 16'h30F0, 8'h20, 16'h0802, 16'h0000);
        run_op("R5",     2'd1, 1'b0, 16'h30F0, 8'h20, 16'h0802, 16'h0000);
        run_op("R6",     2'd1, 1'b1, 16'h3010, 8'h20, 16'h0802, 16'h0000);
        run_op("R6",     2'd1, 1'b0, 16'h30DF, 8'h20, 16'h0802, 16'h0000);
        run_op("R7",     2'd2, 1'b1, 16'h4567, 8'h00, 16'h0000, 16'h0000);
        run_op("R8",     2'd2, 1'b0, 16'h4567, 8'h00, 16'h0000, 16'h0000);
        // R9: stalls on reads, and on write cycles (ignored there)
        run_op("R9 R7",  2'd2, 1'b1, 16'h5A01, 8'h00, 16'h0000, 16'b0000_0000_0001_1110);
        run_op("R9 R8",  2'd2, 1'b0, 16'h5A01, 8'h00, 16'h0000, 16'b0000_0000_0011_0110);
        run_op("R9 R3",  2'd0, 1'b0, 16'h66FF, 8'h00, 16'h0000, 16'b0000_0000_0010_1011);
        run_op("R9 R4",  2'd1, 1'b1, 16'h70FF, 8'h01, 16'h0100, 16'b0000_0000_0000_0101);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule